// File: doc/BRIEF.md
# Auto-Reload Timer with Split and Capture

This block is a 16-bit timer with one control and status register. It runs either as one 16-bit counter that reloads itself when it wraps, or as two independent 8-bit counters, each with its own reload byte. In capture mode the counter never reloads. Instead, a chosen event copies the live count into the reload registers. The event is either a start-of-frame pulse or a falling edge on a slow oscillator input.

The count tick comes from one of two sources. The first is a free-running divide-by-12 of the system clock. The second is a divide-by-8 of an external clock, which is first synchronized into the system clock domain. Each counter byte has its own select input, which chooses between that divided tick and the plain system clock. There is one overflow flag for each byte. Software clears the flags. The high flag, or the low flag when the low-byte interrupt enable is set, raises the interrupt request when the global enable is high.

The register port is a plain single-cycle access with no back-pressure. A write commits on the clock edge while `reg_wr` is high. The read data is a combinational function of `reg_addr`.

Top module: `arl_timer`

## Requirements
- R1: After reset the control byte, both counter bytes and both reload bytes read 0x00, and `irq` is low.
- R2: Register map: address 0 is control, 1 is count low, 2 is count high, 3 is reload low, 4 is reload high. A write to a count byte replaces that byte and holds its counter for that cycle.
- R3: Control bits, from bit 7 down to bit 0, are:
  - high flag
  - low flag
  - low interrupt enable
  - capture enable
  - split
  - run
  - capture source
  - tick source

  With split=0 and `lo_clk_sel`=0, the 16-bit count rises by one on every clock while run=1 and holds while run=0.
- R4: In 16-bit mode with capture off, a step from 0xFFFF loads the 16-bit reload value and sets both flags.
- R5: In 16-bit mode, a step that takes the low byte from 0xFF to 0x00 without a full wrap sets only the low flag.
- R6: In split mode the low byte counts whatever run is, the high byte counts only while run=1, and each byte reloads from its own reload byte and sets its own flag when it wraps.
- R7: The flags stay set until a control write puts 0 in them. A hardware set in the same cycle as that write wins.
- R8: `irq` is high when `irq_en`=1 and either the high flag is set, or the low flag and the low interrupt enable are both set.
- R9: With capture enabled, the counter passes from 0xFFFF to 0x0000 without reloading.
- R10: With capture enabled and capture source 0, a `sof_pulse` copies both count bytes into the reload bytes and sets the high flag.
- R11: With capture source 1, a falling edge of `lfo_in` (after a two-flop synchronizer) captures in the same way, and `sof_pulse` is ignored.
- R12: With tick source 0 and a byte's select input high, that byte advances once every 12 system clocks.
- R13: With tick source 1 and a byte's select input high, that byte advances once for every 8 rising edges of `ext_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ext_clk | input | 1 | Asynchronous external clock |
| sof_pulse | input | 1 | Start-of-frame pulse, one clock wide, synchronous |
| lfo_in | input | 1 | Asynchronous low-frequency oscillator |
| lo_clk_sel | input | 1 | Low byte: 1 = divided tick, 0 = system clock |
| hi_clk_sel | input | 1 | High byte: 1 = divided tick, 0 = system clock |
| irq_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- the count holds while the timer is stopped, and the high byte holds in split mode while run is low;
- a 16-bit wrap either reloads or free-runs, depending on capture enable;
- a capture copies the count into the reload registers;
- flags stay set, and a hardware set beats a same-cycle clear;
- the interrupt gating holds;
- the divided ticks are never wider than one cycle.

The exact tick rates, the latency of the oscillator edge through its synchronizer, the bit positions in the register map, and the fact that the start-of-frame pulse is ignored when the oscillator source is selected only appear in the bench's timed scenarios.

// File: rtl/arl_timer_pkg.sv
package arl_timer_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd4;

  // Control byte, most significant field first.
  typedef struct packed {
    logic ovf_hi;
    logic ovf_lo;
    logic lo_irq_en;
    logic cap_en;
    logic split;
    logic run;
    logic cap_src;
    logic ext_sel;
  } ctrl_t;
endpackage

// File: rtl/arl_sync.sv
module arl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/arl_tick_gen.sv
module arl_tick_gen #(
  parameter int unsigned SYS_DIV     = 12,
  parameter int unsigned EXT_DIV     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  output logic sys_tick,
  output logic ext_tick
);
  localparam int unsigned SYS_W = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;
  localparam logic [SYS_W-1:0] SYS_LAST = SYS_W'(SYS_DIV - 1);

  // System clock prescaler, free running from reset.
  logic [SYS_W-1:0] sys_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sys_cnt <= '0;
    else if (sys_cnt == SYS_LAST) sys_cnt <= '0;
    else                          sys_cnt <= sys_cnt + 1'b1;
  end
  assign sys_tick = (sys_cnt == SYS_LAST);

  // External clock: synchronize, detect rising edge, divide.
  logic ext_s, ext_d, ext_rise;
  arl_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_clk), .q(ext_s)
  );
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_d <= 1'b0;
    else        ext_d <= ext_s;
  end
  assign ext_rise = ext_s & ~ext_d;

  generate
    if (EXT_DIV <= 1) begin : g_ext_nodiv
      assign ext_tick = ext_rise;
    end else begin : g_ext_div
      localparam int unsigned EXT_W = $clog2(EXT_DIV);
      localparam logic [EXT_W-1:0] EXT_LAST = EXT_W'(EXT_DIV - 1);
      logic [EXT_W-1:0] ext_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_cnt <= '0;
        else if (ext_rise) begin
          if (ext_cnt == EXT_LAST) ext_cnt <= '0;
          else                     ext_cnt <= ext_cnt + 1'b1;
        end
      end
      assign ext_tick = ext_rise && (ext_cnt == EXT_LAST);
    end
  endgenerate

  // R12: the prescaled tick is a single-cycle pulse
  p_sys_tick_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sys_tick |=> !sys_tick);
  // R13: the external tick is a single-cycle pulse
  p_ext_tick_gap_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ext_tick |=> !ext_tick);
endmodule

// File: rtl/arl_capture_sel.sv
module arl_capture_sel #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic cap_src,
  input  logic sof_pulse,
  input  logic lfo_in,
  output logic cap_evt
);
  logic lfo_s, lfo_d, lfo_fall;

  arl_sync #(.STAGES(SYNC_STAGES)) u_lfo_sync (
    .clk(clk), .rst_n(rst_n), .d(lfo_in), .q(lfo_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfo_d <= 1'b0;
    else        lfo_d <= lfo_s;
  end

  assign lfo_fall = lfo_d & ~lfo_s;
  assign cap_evt  = cap_en & (cap_src ? lfo_fall : sof_pulse);

  // R11: a falling edge cannot be seen on two cycles in a row
  p_fall_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lfo_fall |=> !lfo_fall);
endmodule

// File: rtl/arl_counter.sv
module arl_counter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  split_i,
  input  logic                  run_i,
  input  logic                  cap_en_i,
  input  logic                  lo_adv_i,
  input  logic                  hi_adv_i,
  input  logic                  wr_cnt_lo_i,
  input  logic                  wr_cnt_hi_i,
  input  logic                  wr_rld_lo_i,
  input  logic                  wr_rld_hi_i,
  input  logic [BYTE_W-1:0]     wr_data_i,
  input  logic                  cap_evt_i,
  output logic [2*BYTE_W-1:0]   cnt_o,
  output logic [2*BYTE_W-1:0]   rld_o,
  output logic                  wrap_hi_o,
  output logic                  wrap_lo_o
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_q, hi_q, lo_n, hi_n;
  logic [BYTE_W-1:0] rlo_q, rhi_q, rlo_n, rhi_n;
  logic [CNT_W-1:0]  full_inc;
  logic              lo_full, hi_full;
  logic              step16, step_lo, step_hi;

  assign lo_full  = &lo_q;
  assign hi_full  = &hi_q;
  assign full_inc = {hi_q, lo_q} + 1'b1;

  assign step16  = !split_i && run_i && lo_adv_i && !wr_cnt_lo_i && !wr_cnt_hi_i;
  assign step_lo =  split_i && lo_adv_i && !wr_cnt_lo_i;
  assign step_hi =  split_i && run_i && hi_adv_i && !wr_cnt_hi_i;

  always_comb begin
    lo_n      = lo_q;
    hi_n      = hi_q;
    wrap_hi_o = 1'b0;
    wrap_lo_o = 1'b0;

    if (step16) begin
      wrap_lo_o = lo_full;
      if (lo_full && hi_full) begin
        wrap_hi_o = 1'b1;
        if (cap_en_i) {hi_n, lo_n} = full_inc;
        else          {hi_n, lo_n} = {rhi_q, rlo_q};
      end else begin
        {hi_n, lo_n} = full_inc;
      end
    end

    if (step_lo) begin
      wrap_lo_o = lo_full;
      if (lo_full && !cap_en_i) lo_n = rlo_q;
      else                      lo_n = lo_q + 1'b1;
    end

    if (step_hi) begin
      wrap_hi_o = hi_full;
      if (hi_full && !cap_en_i) hi_n = rhi_q;
      else                      hi_n = hi_q + 1'b1;
    end

    if (wr_cnt_lo_i) lo_n = wr_data_i;
    if (wr_cnt_hi_i) hi_n = wr_data_i;
  end

  always_comb begin
    rlo_n = rlo_q;
    rhi_n = rhi_q;
    if (cap_evt_i) begin
      rlo_n = lo_q;
      rhi_n = hi_q;
    end
    if (wr_rld_lo_i) rlo_n = wr_data_i;
    if (wr_rld_hi_i) rhi_n = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      rlo_q <= '0;
      rhi_q <= '0;
    end else begin
      lo_q  <= lo_n;
      hi_q  <= hi_n;
      rlo_q <= rlo_n;
      rhi_q <= rhi_n;
    end
  end

  assign cnt_o = {hi_q, lo_q};
  assign rld_o = {rhi_q, rlo_q};

  // R3: a stopped 16-bit counter keeps its value
  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!split_i && !run_i && !wr_cnt_lo_i && !wr_cnt_hi_i) |=> $stable(cnt_o));
  // R6: in split mode the high byte is frozen while run is low
  p_split_hi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (split_i && !run_i && !wr_cnt_hi_i) |=> $stable(hi_q));
  // R4: a full wrap without capture loads the reload pair
  p_wrap_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step16 && lo_full && hi_full && !cap_en_i) |=> (cnt_o == $past(rld_o)));
  // R9: a full wrap with capture enabled lands on zero
  p_free_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step16 && lo_full && hi_full && cap_en_i) |=> (cnt_o == '0));
  // R10: a capture event copies the count into the reload pair
  p_capture_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt_i && !wr_rld_lo_i && !wr_rld_hi_i) |=> (rld_o == $past(cnt_o)));
endmodule

// File: rtl/arl_timer.sv
module arl_timer
  import arl_timer_pkg::*;
#(
  parameter int unsigned SYS_DIV     = 12,
  parameter int unsigned EXT_DIV     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              ext_clk,
  input  logic              sof_pulse,
  input  logic              lfo_in,
  input  logic              lo_clk_sel,
  input  logic              hi_clk_sel,
  input  logic              irq_en,
  output logic              irq
);
  localparam int unsigned BYTE_W = 8;

  ctrl_t             ctrl_q, ctrl_n;
  logic              wr_ctrl, wr_cnt_lo, wr_cnt_hi, wr_rld_lo, wr_rld_hi;
  logic              sys_tick, ext_tick, div_tick, lo_adv, hi_adv;
  logic              cap_evt, wrap_hi, wrap_lo;
  logic [2*BYTE_W-1:0] cnt, rld;

  assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
  assign wr_cnt_lo = reg_wr && (reg_addr == A_CNT_LO);
  assign wr_cnt_hi = reg_wr && (reg_addr == A_CNT_HI);
  assign wr_rld_lo = reg_wr && (reg_addr == A_RLD_LO);
  assign wr_rld_hi = reg_wr && (reg_addr == A_RLD_HI);

  arl_tick_gen #(
    .SYS_DIV(SYS_DIV), .EXT_DIV(EXT_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk),
    .sys_tick(sys_tick), .ext_tick(ext_tick)
  );

  assign div_tick = ctrl_q.ext_sel ? ext_tick : sys_tick;
  assign lo_adv   = lo_clk_sel ? div_tick : 1'b1;
  assign hi_adv   = hi_clk_sel ? div_tick : 1'b1;

  arl_capture_sel #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .cap_en(ctrl_q.cap_en), .cap_src(ctrl_q.cap_src),
    .sof_pulse(sof_pulse), .lfo_in(lfo_in),
    .cap_evt(cap_evt)
  );

  arl_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .split_i(ctrl_q.split), .run_i(ctrl_q.run), .cap_en_i(ctrl_q.cap_en),
    .lo_adv_i(lo_adv), .hi_adv_i(hi_adv),
    .wr_cnt_lo_i(wr_cnt_lo), .wr_cnt_hi_i(wr_cnt_hi),
    .wr_rld_lo_i(wr_rld_lo), .wr_rld_hi_i(wr_rld_hi),
    .wr_data_i(reg_wdata), .cap_evt_i(cap_evt),
    .cnt_o(cnt), .rld_o(rld),
    .wrap_hi_o(wrap_hi), .wrap_lo_o(wrap_lo)
  );

  // Control register; hardware flag sets take priority over a clearing write.
  always_comb begin
    ctrl_n = ctrl_q;
    if (wr_ctrl) ctrl_n = ctrl_t'(reg_wdata);
    ctrl_n.ovf_hi = ctrl_n.ovf_hi | wrap_hi | cap_evt;
    ctrl_n.ovf_lo = ctrl_n.ovf_lo | wrap_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_n;
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:   reg_rdata = ctrl_q;
      A_CNT_LO: reg_rdata = cnt[BYTE_W-1:0];
      A_CNT_HI: reg_rdata = cnt[2*BYTE_W-1:BYTE_W];
      A_RLD_LO: reg_rdata = rld[BYTE_W-1:0];
      A_RLD_HI: reg_rdata = rld[2*BYTE_W-1:BYTE_W];
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = irq_en & (ctrl_q.ovf_hi | (ctrl_q.ovf_lo & ctrl_q.lo_irq_en));

  // R7: flags hold unless a control write comes
  p_flag_hold_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.ovf_hi && !wr_ctrl) |=> ctrl_q.ovf_hi);
  p_flag_hold_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.ovf_lo && !wr_ctrl) |=> ctrl_q.ovf_lo);
  // R7: a hardware set beats a same-cycle clear
  p_flag_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_hi || cap_evt) |=> ctrl_q.ovf_hi);
  // R8: interrupt gating
  p_irq_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && ctrl_q.ovf_hi) |-> irq);
  p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

// File: tb/arl_timer_bench.sv
module arl_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ext_clk = 1'b0, sof_pulse = 1'b0, lfo_in = 1'b0;
  logic       lo_clk_sel = 1'b0, hi_clk_sel = 1'b0, irq_en = 1'b0;
  logic       irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  arl_timer u_arl_timer (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_clk(ext_clk),
    .sof_pulse(sof_pulse), .lfo_in(lfo_in), .lo_clk_sel(lo_clk_sel),
    .hi_clk_sel(hi_clk_sel), .irq_en(irq_en), .irq(irq)
  );

  // Scoreboard item: sel 0..4 = register address, 8 = irq pin.
  typedef struct {
    logic [3:0] sel;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t exp_q[$];
  int    checks = 0, errors = 0, queued = 0, served = 0;
  bit    done = 1'b0;

  // Monitor: pops each expected item and compares it with the design.
  initial begin
    forever begin
      item_t      it;
      logic [7:0] act;
      wait (exp_q.size() > 0);
      #1;
      it  = exp_q.pop_front();
      act = (it.sel == 4'd8) ? {7'b0, irq} : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.req, it.sel, act, it.exp);
      end
      served++;
    end
  end

  // Driver side: push an expectation and wait for the monitor to handle it.
  task automatic chk(input logic [3:0] sel, input logic [7:0] exp, input string req);
    item_t it;
    if (sel < 4'd8) reg_addr = sel[2:0];
    it.sel = sel; it.exp = exp; it.req = req;
    queued++;
    exp_q.push_back(it);
    wait (served == queued);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sof();
    @(negedge clk); sof_pulse = 1'b1;
    @(negedge clk); sof_pulse = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1: reset state
    chk(4'd0, 8'h00, "R1 ctrl");
    chk(4'd1, 8'h00, "R1 cnt_lo");
    chk(4'd2, 8'h00, "R1 cnt_hi");
    idle(1);
    chk(4'd3, 8'h00, "R1 rld_lo");
    chk(4'd4, 8'h00, "R1 rld_hi");
    chk(4'd8, 8'h00, "R1 irq");

    // R3 / R2: 16-bit count on the system clock, then stop
    wr(3'd0, 8'h04);
    idle(5);
    chk(4'd1, 8'h05, "R3 count after 5 clocks");
    chk(4'd2, 8'h00, "R2 cnt_hi address");
    wr(3'd0, 8'h00);
    idle(3);
    chk(4'd1, 8'h07, "R3 held while stopped");

    // R4: full wrap reloads and sets both flags
    wr(3'd3, 8'h34);
    wr(3'd4, 8'h12);
    wr(3'd1, 8'hFE);
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'h04);
    idle(2);
    chk(4'd1, 8'h34, "R4 reload lo");
    chk(4'd2, 8'h12, "R4 reload hi");
    chk(4'd0, 8'hC4, "R4 both flags");
    idle(3);
    chk(4'd0, 8'hC4, "R7 flags sticky");
    wr(3'd0, 8'h00);
    chk(4'd0, 8'h00, "R7 flags cleared by write");

    // R5: low byte rollover only
    wr(3'd1, 8'hFF);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h04);
    idle(1);
    chk(4'd0, 8'h44, "R5 low flag only");
    chk(4'd2, 8'h01, "R5 carry into hi");
    chk(4'd1, 8'h00, "R5 lo wrapped");
    wr(3'd0, 8'h00);

    // R8: interrupt gating
    irq_en = 1'b1;
    wr(3'd0, 8'h40);
    chk(4'd8, 8'h00, "R8 low flag masked");
    wr(3'd0, 8'h60);
    chk(4'd8, 8'h01, "R8 low flag enabled");
    wr(3'd0, 8'h80);
    chk(4'd8, 8'h01, "R8 high flag");
    irq_en = 1'b0;
    chk(4'd8, 8'h00, "R8 global disable");
    irq_en = 1'b1;
    wr(3'd0, 8'h00);

    // R6: split mode
    wr(3'd3, 8'hF0);
    wr(3'd4, 8'h80);
    wr(3'd1, 8'hFD);
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'h08);
    idle(3);
    chk(4'd1, 8'hF0, "R6 low reload from own byte");
    chk(4'd2, 8'hFF, "R6 high held without run");
    chk(4'd0, 8'h48, "R6 low flag in split");
    wr(3'd0, 8'h0C);
    idle(1);
    chk(4'd2, 8'h80, "R6 high reload from own byte");
    chk(4'd1, 8'hF3, "R6 low kept counting");
    chk(4'd0, 8'h8C, "R6 high flag in split");
    wr(3'd0, 8'h00);

    // R9: capture enabled, free run through wrap
    wr(3'd3, 8'h55);
    wr(3'd4, 8'h66);
    wr(3'd1, 8'hFF);
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'h14);
    idle(1);
    chk(4'd1, 8'h00, "R9 lo free-run");
    chk(4'd2, 8'h00, "R9 hi free-run");
    chk(4'd3, 8'h55, "R9 reload untouched");
    chk(4'd0, 8'hD4, "R9 flags");
    wr(3'd0, 8'h10);

    // R10: start-of-frame capture
    wr(3'd1, 8'h3C);
    wr(3'd2, 8'hA5);
    pulse_sof();
    chk(4'd3, 8'h3C, "R10 captured lo");
    chk(4'd4, 8'hA5, "R10 captured hi");
    chk(4'd0, 8'h90, "R10 high flag");
    chk(4'd8, 8'h01, "R10 irq");

    // R11: oscillator source; frame pulse ignored
    wr(3'd0, 8'h12);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h00);
    pulse_sof();
    chk(4'd3, 8'h00, "R11 sof ignored");
    chk(4'd0, 8'h12, "R11 no flag on sof");
    wr(3'd1, 8'h88);
    wr(3'd2, 8'h77);
    lfo_in = 1'b1;
    idle(4);
    lfo_in = 1'b0;
    idle(5);
    chk(4'd3, 8'h88, "R11 lfo captured lo");
    chk(4'd4, 8'h77, "R11 lfo captured hi");
    chk(4'd0, 8'h92, "R11 high flag");

    // R12: system clock divided by 12
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00);
    lo_clk_sel = 1'b1;
    wr(3'd0, 8'h04);
    idle(22);
    wr(3'd0, 8'h00);
    idle(2);
    chk(4'd1, 8'h02, "R12 two ticks in 24 clocks");
    chk(4'd2, 8'h00, "R12 hi unchanged");

    // R13: external clock divided by 8
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h05);
    for (int i = 0; i < 16; i++) begin
      ext_clk = 1'b1; idle(2);
      ext_clk = 1'b0; idle(2);
    end
    idle(6);
    wr(3'd0, 8'h00);
    chk(4'd1, 8'h02, "R13 two ticks in 16 edges");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule